// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that connects a host on a two-wire bus to a small bank of byte-wide registers. A fast system clock oversamples SCL and SDA. Two-flop synchronizers and edge detectors pick out clock edges, START, repeated START and STOP. The block answers one fixed 7-bit device address (binary 1100000). It pulls SDA low through an output enable, which gives open-drain behaviour.

A write transaction sends the device address with R/W=0 and then a pointer byte. The pointer byte selects the starting register. Each data byte after that lands in the register at the pointer, and the pointer then moves forward. A read first sets the pointer the same way. The host then issues a repeated START with R/W=1, and the block streams registers out starting at the pointer. The register contents come out in parallel on one bus. Read data is taken from a separate read-back bus at the same positions, so the surrounding logic can loop the bank back or substitute live values.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset every register reads 0, the pointer is 0 and SDA is released (output enable low).
- R2: The block acknowledges only the first bytes 0xC0 (write) and 0xC1 (read). On any other address it drives no ACK, and it stays silent and ignores every bit until the next START.
- R3: In a write transaction the byte after the address is acknowledged and loads the pointer from its low 4 bits. Bits 7..4 of that byte are ignored.
- R4: Each later write byte is taken MSB first and acknowledged. It is stored in the register at the pointer, register k occupying bits 8k+7..8k of the bank output, and the pointer then advances by one.
- R5: The pointer wraps from 15 to 0 on writes and on acknowledged reads.
- R6: A write transaction accepts any number of data bytes until a STOP. A repeated START returns the block to the address phase.
- R7: After a repeated START with 0xC1 the block acknowledges. It then shifts out the read-back bus byte at the pointer, MSB first, one bit per SCL clock.
- R8: A host ACK on the 9th clock of a read byte advances the pointer and starts the next byte. A host NACK leaves the pointer unchanged, and the block drives SDA no more until the next STOP or START.
- R9: The output enable is asserted only to pull SDA low, and it changes only while SCL is low.
- R10: The pointer keeps its value across transactions. A read that does not set the pointer starts where the previous transaction left it.
- R11: Writing 0x0E, 0xD8, 0xE1 to registers 0..2 in one transaction and reading registers 0..2 back returns the same three bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| regs_q | output | 128 | Register bank contents, register k at bits 8k+7..8k |
| rb_i | input | 128 | Read-back bus, byte k returned when register k is read |

## Verification
The bench aims at the pointer edges. It writes through register 15 into register 0, uses a pointer byte with its upper bits set, and reads across the wrap. A design that saturated the pointer or used all eight bits would write the wrong register or return the wrong byte. It sends a wrong device address followed by a further byte, and then clocks a byte after a read NACK. A design that kept listening, or that kept driving after the NACK, would show an ACK or zero bits where the line must stay high. The bench also breaks a write with a repeated START, and starts a read without a pointer byte after a NACK-terminated read. An off-by-one in the pointer update around NACK, or a pointer reset at STOP, shows up as the wrong register being returned.

// File: rtl/i2c_rb_pkg.sv
// Shared definitions for the I2C register-bank target.
// Assumes byte-wide registers; the bus always moves 8 bits per frame.
package i2c_rb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RLOAD,
        ST_RDATA,
        ST_RACK,
        ST_HOLD
    } tgt_state_e;
endpackage

// File: rtl/i2c_rb_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and flags SCL
// edges, START and STOP. Assumes SCL and SDA are slow next to clk, so
// that each level lasts several clk cycles.
module i2c_rb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_d;
    logic         sda_d;
    logic         scl_s;

    // Synchronizer chains plus one history flop per line; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_d    <= scl_pipe[TOP];
            sda_d    <= sda_pipe[TOP];
        end
    end

    // Edge and bus-condition decode from the synchronized and delayed levels.
    always_comb begin
        scl_s     = scl_pipe[TOP];
        sda_s     = sda_pipe[TOP];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_rb_proto.sv
// Bus protocol engine: address match, pointer byte, write data, read data
// and ACK handling. It owns the register pointer. Assumes single-cycle
// edge strobes from the synchronizer, and it changes SDA only after a
// detected SCL fall.
module i2c_rb_proto
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60,
    parameter int         PTR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output tgt_state_e        state
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [3:0]        bitcnt;
    logic              rw;
    logic              host_ack;
    logic              byte_end;

    // A byte ends on the SCL fall that follows its eighth rising edge.
    always_comb byte_end = scl_fall && (bitcnt == LAST_BIT);

    // Main transaction sequencer; START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            shreg    <= '0;
            tx       <= '0;
            bitcnt   <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= rw ? ST_RLOAD : ST_PTR;
                        end
                    end
                    ST_PTR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            ptr    <= shreg[PTR_W-1:0];
                            sda_oe <= 1'b1;
                            state  <= ST_PTR_ACK;
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= ptr;
                            wr_data <= shreg;
                            ptr     <= ptr + 1'b1;
                            sda_oe  <= 1'b1;
                            state   <= ST_WDATA_ACK;
                        end
                    end
                    ST_RLOAD: begin
                        tx     <= rd_byte;
                        sda_oe <= ~rd_byte[BYTE_W-1];
                        bitcnt <= '0;
                        state  <= ST_RDATA;
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else if (scl_fall) begin
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_RLOAD;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_rb_bank.sv
// Register storage and read-back selection. Holds REG_COUNT byte
// registers with a single write port. The read side picks one byte of
// the external read-back bus by index.
module i2c_rb_bank
    import i2c_rb_pkg::*;
#(
    parameter int REG_COUNT = 16,
    parameter int PTR_W     = 4,
    parameter int BANK_W    = REG_COUNT * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_sel,
    input  logic [BANK_W-1:0] rb_flat,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BANK_W-1:0] regs_flat
);
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        // One register slot, loaded when the write index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_flat[g*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(g))) begin
                regs_flat[g*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    // Read-back byte chosen by the pointer.
    always_comb rd_byte = rb_flat[rd_sel*BYTE_W +: BYTE_W];
endmodule

// File: rtl/i2c_regbank_target.sv
// Top of the I2C register-bank target. It wires the line synchronizer,
// the protocol engine and the register bank. SDA is open-drain: sda_oe
// high means pull low. REG_COUNT must be a power of two so that the
// pointer wraps naturally.
module i2c_regbank_target
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h60,
    parameter int         REG_COUNT   = 16,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(REG_COUNT),
    localparam int        BANK_W      = REG_COUNT * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BANK_W-1:0] regs_q,
    input  logic [BANK_W-1:0] rb_i
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_byte;
    tgt_state_e        st;

    i2c_rb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_proto #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) proto_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .state     (st)
    );

    i2c_rb_bank #(.REG_COUNT(REG_COUNT), .PTR_W(PTR_W), .BANK_W(BANK_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_sel    (ptr),
        .rb_flat   (rb_i),
        .rd_byte   (rd_byte),
        .regs_flat (regs_q)
    );
endmodule

// File: rtl/i2c_regbank_target_chk.sv
// Property checker for the I2C register-bank target, bound into the top.
// Observes ports and the internal strobes between sub-blocks.
module i2c_regbank_target_chk
    import i2c_rb_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int BANK_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input tgt_state_e        state,
    input logic [PTR_W-1:0]  ptr,
    input logic              wr_en,
    input logic [PTR_W-1:0]  wr_idx,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BANK_W-1:0] regs_q,
    input logic              stop_det
);
    logic [PTR_W-1:0]  idx_q;
    logic [BYTE_W-1:0] dat_q;

    // Remember the last write request for the landing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            idx_q <= wr_idx;
            dat_q <= wr_data;
        end
    end

    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[idx_q*BYTE_W +: BYTE_W] == dat_q));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == PTR_W'(wr_idx + 1'b1)));

    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_oe);
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.PTR_W(PTR_W), .BANK_W(BANK_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .state    (st),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .regs_q   (regs_q),
    .stop_det (stop_det)
);

// File: tb/i2c_regbank_target_tb_top.sv
// Self-checking bench: a bit-banged bus host, a reference register model,
// directed corner cases and seeded random transactions.
module i2c_regbank_target_tb_top;
    localparam int NREG = 16;
    localparam int BW   = NREG * 8;
    localparam int Q    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_h = 1'b1;
    logic          rb_force = 1'b0;
    logic          sda_oe;
    logic [BW-1:0] regs_q;
    logic [BW-1:0] rb_bus;
    logic          sda_line;

    int            vectors = 0;
    int            fails = 0;
    logic [7:0]    mem [NREG];
    int            mptr = 0;
    logic [7:0]    wbuf [8];

    always #10 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;
    assign rb_bus   = rb_force ? ~regs_q : regs_q;

    i2c_regbank_target dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_q (regs_q),
        .rb_i   (rb_bus)
    );

    function automatic logic [7:0] exp_read(int idx);
        return rb_force ? ~mem[idx] : mem[idx];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_h = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0;   wq(Q);
        sda_h = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_h = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_line);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0;    wq(Q);
            sda_h = b[i];  wq(Q);
            scl = 1'b1;    wq(2*Q);
        end
        scl = 1'b0;   wq(Q);
        sda_h = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack_line = sda_line;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; sda_h = 1'b1; wq(2*Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
        end
        scl = 1'b0;          wq(Q);
        sda_h = ~give_ack;   wq(Q);
        scl = 1'b1;          wq(2*Q);
        scl = 1'b0;          wq(Q);
        sda_h = 1'b1;
    endtask

    // Write n bytes from wbuf starting at pointer byte p, updating the model.
    task automatic host_write(input logic [7:0] p, input int n);
        logic a;
        bus_start();
        send_byte(8'hC0, a); chk("R2 write address ack", a, 0);
        send_byte(p, a);     chk("R3 pointer ack", a, 0);
        mptr = p % NREG;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a); chk("R4 data ack", a, 0);
            mem[mptr] = wbuf[k];
            mptr = (mptr + 1) % NREG;
        end
        bus_stop();
    endtask

    // Read n bytes, optionally setting the pointer first, checking each one.
    task automatic host_read(input logic set_ptr, input logic [7:0] p, input int n,
                             input string req);
        logic a;
        logic [7:0] d;
        bus_start();
        if (set_ptr) begin
            send_byte(8'hC0, a); chk("R2 write address ack", a, 0);
            send_byte(p, a);     chk("R3 pointer ack", a, 0);
            mptr = p % NREG;
            bus_start();
        end
        send_byte(8'hC1, a); chk("R7 read address ack", a, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            chk(req, d, exp_read(mptr));
            if (k < n - 1) mptr = (mptr + 1) % NREG;
        end
        bus_stop();
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) chk(req, regs_q[i*8 +: 8], mem[i]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        void'($urandom(32'd7321));
        for (int i = 0; i < NREG; i++) mem[i] = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        chk("R1 sda released after reset", sda_oe, 0);
        check_bank("R1 registers zero after reset");

        // R11 round trip of three bytes
        wbuf[0] = 8'h0E; wbuf[1] = 8'hD8; wbuf[2] = 8'hE1;
        host_write(8'h00, 3);
        check_bank("R4 bank after write");
        host_read(1'b1, 8'h00, 3, "R11 round trip read");

        // R10 pointer kept: NACK left it at register 2
        host_read(1'b0, 8'h00, 1, "R10 pointer retained");

        // R2 wrong address, then an extra byte that must be ignored
        bus_start();
        send_byte(8'hC2, a); chk("R2 mismatch not acked", a, 1);
        send_byte(8'h00, a); chk("R9 line left released after mismatch", a, 1);
        bus_stop();
        check_bank("R2 bank untouched after mismatch");

        // R3 upper pointer bits ignored, R5 write wrap 15 -> 0
        wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
        host_write(8'h1F, 2);
        chk("R5 reg15 after wrap write", regs_q[15*8 +: 8], 8'hAA);
        chk("R5 reg0 after wrap write", regs_q[0 +: 8], 8'h55);
        host_read(1'b1, 8'h0F, 3, "R5 read wrap");

        // R6 repeated START inside a write
        bus_start();
        send_byte(8'hC0, a); chk("R2 write address ack", a, 0);
        send_byte(8'h05, a); chk("R3 pointer ack", a, 0);
        send_byte(8'h11, a); chk("R6 data ack", a, 0);
        mem[5] = 8'h11;
        bus_start();
        send_byte(8'hC0, a); chk("R6 address after repeated start", a, 0);
        send_byte(8'h06, a); chk("R6 pointer after repeated start", a, 0);
        send_byte(8'h22, a); chk("R6 data ack", a, 0);
        mem[6] = 8'h22;
        bus_stop();
        check_bank("R6 bank after split write");

        // R8 silent after NACK: an extra clocked byte reads all ones
        bus_start();
        send_byte(8'hC0, a);
        send_byte(8'h05, a);
        bus_start();
        send_byte(8'hC1, a); chk("R7 read address ack", a, 0);
        recv_byte(1'b0, d);  chk("R8 byte before nack", d, 8'h11);
        recv_byte(1'b0, d);  chk("R8 released after nack", d, 8'hFF);
        bus_stop();
        mptr = 5;

        // R7 data comes from the read-back bus
        rb_force = 1'b1;
        host_read(1'b1, 8'h06, 2, "R7 read-back bus select");
        rb_force = 1'b0;

        // Seeded random write/read sequences
        for (int it = 0; it < 15; it++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom_range(255, 0));
            n = 1 + $urandom_range(4, 0);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom_range(255, 0));
            host_write(p, n);
            check_bank("R4 random write");
            host_read(1'b1, p, n, "R7 random read back");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule